// File: doc/BRIEF.md
# SMM Memory Window Controller

This block keeps the configuration that decides where system-management memory is visible in a chipset. Three configuration registers are written over a small write port. The first is an 8-bit window control register. The second is an 8-bit extended window control register. The third is a 16-bit extended TSEG size register. Each 8-bit register passes writes through a write mask. A lock bit seals the configuration: sealing clears the open bit in the same update and reduces both masks to zero. The masks stay reduced until reset.

From the register contents the block derives registered routing decisions. Non-SMM accesses get a low-window choice between RAM and PCI, and an enable for the high alias. SMM accesses get enables for low SMRAM and high SMRAM. The block also drives a TSEG enable, base and length. TSEG sits directly below the top of low memory, which is given on `top_low_mem`. An access lookup port flags non-SMM accesses that fall inside TSEG. For such an access the memory fabric returns all-ones on a read and discards a write.

The lock logic is a two-state machine. `LK_OPEN` is the reset state and uses the full write masks. It moves to `LK_SEALED` on a window-control write whose masked result has the lock bit set. `LK_SEALED` uses the sealed masks, keeps the open bit clear, and has no exit except reset.

Top module: `smm_window_ctrl`

## Requirements
- R1: On reset the registers take these values: window control 0x02, extended control 0x38, extended size 0xFFFF (when the configured megabyte count `EXT_MB` is nonzero). All routing outputs are 0 and the TSEG length is 0.
- R2: Window control layout: bit 6 open, bit 4 lock, bit 3 global enable. Only bits 6..3 are writable (mask 0x78); bits 2..0 read 010. Extended control layout: bit 7 high enable, bits 2..1 TSEG size, bit 0 TSEG enable. Only bits 7, 2, 1 and 0 are writable (mask 0x87). The other bits keep their values.
- R3: A window-control write that leaves the lock bit set clears the open bit in the same update. After it, writes to both control registers have no effect until reset, while the extended size register stays writable. Reset restores the full masks.
- R4: For non-SMM accesses, `nsmm_low_ram` = open AND NOT high-enable, and `nsmm_high_ram` = open AND high-enable. With open clear, both are 0, so the low window goes to PCI and the high alias is off.
- R5: For SMM accesses, `smm_low_ram` = global AND NOT high-enable, and `smm_high_ram` = global AND high-enable.
- R6: `tseg_en` = TSEG enable AND global. The size codes are 00 = 1 MiB, 01 = 2 MiB, 10 = 8 MiB and 11 = `EXT_MB` MiB. `tseg_len` is 0 when TSEG is off.
- R7: `tseg_base` = `top_low_mem` − `tseg_len`, so TSEG covers [`tseg_base`, `top_low_mem`).
- R8: `acc_blocked` is 1 exactly when TSEG is on, `acc_smm` is 0, and `acc_addr` lies in [`tseg_base`, `top_low_mem`). SMM accesses are never blocked.
- R9: A write of 0xFFFF to the extended size register stores `EXT_MB` when `EXT_MB` is nonzero. Any other value is stored unchanged.
- R10: The routing and TSEG outputs follow the registers one clock later. They change on the edge after the one that captures the configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target register: 0 window control, 1 extended control, 2 extended size, 3 none |
| cfg_wdata | input | 16 | Write data; the 8-bit registers use bits 7..0 |
| top_low_mem | input | ADDR_W | Top of low memory, held stable |
| acc_addr | input | ADDR_W | Address of an access to classify |
| acc_smm | input | 1 | The access is made in SMM |
| ctl_val | output | 8 | Window control register |
| ectl_val | output | 8 | Extended control register |
| ext_val | output | 16 | Extended size register |
| nsmm_low_ram | output | 1 | Non-SMM low window goes to RAM (else PCI) |
| nsmm_high_ram | output | 1 | Non-SMM high alias enabled |
| smm_low_ram | output | 1 | SMM sees low SMRAM |
| smm_high_ram | output | 1 | SMM sees high SMRAM |
| tseg_en | output | 1 | TSEG active |
| tseg_base | output | ADDR_W | TSEG start address |
| tseg_len | output | ADDR_W | TSEG length in bytes |
| acc_blocked | output | 1 | Non-SMM access inside TSEG: read all-ones, write dropped |

## Verification
The hardest case to reach is the sealed state together with the frozen masks. Once the lock bit is written, every later write to either control register must leave it unchanged. Only a reset can undo this, so the stimulus runs all non-sealing vectors first. It then writes the lock together with the open bit, and tries writes to both control registers and the size register. Finally it pulses reset mid-run to show that the full masks come back.

// File: rtl/smm_win_pkg.sv
package smm_win_pkg;
    localparam int OPEN_B = 6;
    localparam int LOCK_B = 4;
    localparam int GEN_B  = 3;
    localparam int HEN_B  = 7;
    localparam int TEN_B  = 0;
    localparam int MB_SHIFT = 20;
    localparam int EXT_MB_MAX = 4095;

    localparam logic [7:0] CTL_RST         = 8'h02;
    localparam logic [7:0] CTL_MASK_FULL   = 8'h78;
    localparam logic [7:0] CTL_MASK_SEALED = 8'h00;
    localparam logic [7:0] ECTL_RST         = 8'h38;
    localparam logic [7:0] ECTL_MASK_FULL   = 8'h87;
    localparam logic [7:0] ECTL_MASK_SEALED = 8'h00;
    localparam logic [15:0] EXT_QUERY = 16'hFFFF;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_ECTL = 2'd1,
        SEL_EXT  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic nsmm_low_ram;
        logic nsmm_high_ram;
        logic smm_low_ram;
        logic smm_high_ram;
        logic tseg_en;
    } route_t;
endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
    import smm_win_pkg::*;
#(
    parameter int EXT_MB = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    output logic [7:0]  ctl_q,
    output logic [7:0]  ectl_q,
    output logic [15:0] ext_q
);
    localparam logic [15:0] EXT_MB_V = 16'(EXT_MB);
    localparam logic [15:0] EXT_RST  = (EXT_MB > 0) ? EXT_QUERY : 16'h0000;

    generate
        if (EXT_MB < 0 || EXT_MB > EXT_MB_MAX) begin : g_bad_ext
            $error("EXT_MB out of range");
        end
    endgenerate

    lock_state_e lk_state, lk_next;
    logic [7:0]  ctl_mask, ectl_mask;
    logic [7:0]  ctl_merge, ctl_d, ectl_d;
    logic [15:0] ext_d;
    logic        ctl_wr, ectl_wr, ext_wr;

    assign ctl_wr  = cfg_we && (cfg_sel == SEL_CTL);
    assign ectl_wr = cfg_we && (cfg_sel == SEL_ECTL);
    assign ext_wr  = cfg_we && (cfg_sel == SEL_EXT);
    assign ctl_merge = (ctl_q & ~ctl_mask) | (cfg_wdata[7:0] & ctl_mask);

    // lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_state <= LK_OPEN;
        else        lk_state <= lk_next;
    end

    // next state and per-state write masks
    always_comb begin
        lk_next   = lk_state;
        ctl_mask  = CTL_MASK_FULL;
        ectl_mask = ECTL_MASK_FULL;
        unique case (lk_state)
            LK_OPEN: begin
                if (ctl_wr && ctl_merge[LOCK_B]) lk_next = LK_SEALED;
            end
            LK_SEALED: begin
                ctl_mask  = CTL_MASK_SEALED;
                ectl_mask = ECTL_MASK_SEALED;
            end
        endcase
    end

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d = ctl_merge;
            if (ctl_merge[LOCK_B]) ctl_d[OPEN_B] = 1'b0;
        end
        ectl_d = ectl_q;
        if (ectl_wr) ectl_d = (ectl_q & ~ectl_mask) | (cfg_wdata[7:0] & ectl_mask);
        ext_d = ext_q;
        if (ext_wr) begin
            if ((EXT_MB > 0) && (cfg_wdata == EXT_QUERY)) ext_d = EXT_MB_V;
            else                                          ext_d = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RST;
            ectl_q <= ECTL_RST;
            ext_q  <= EXT_RST;
        end else begin
            ctl_q  <= ctl_d;
            ectl_q <= ectl_d;
            ext_q  <= ext_d;
        end
    end

    assert_sealed_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state == LK_SEALED) |=> ($stable(ctl_q) && $stable(ectl_q)));
    assert_sealed_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state == LK_SEALED) |-> !ctl_q[OPEN_B]);
    assert_query_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr && (cfg_wdata == EXT_QUERY) && (EXT_MB > 0)) |=> (ext_q == EXT_MB_V));
endmodule

// File: rtl/smm_route.sv
module smm_route
    import smm_win_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EXT_MB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              gen_i,
    input  logic              hen_i,
    input  logic              ten_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] top_low_mem,
    output route_t            route_q,
    output logic [ADDR_W-1:0] tseg_base_q,
    output logic [ADDR_W-1:0] tseg_len_q
);
    route_t            route_d;
    logic [11:0]       size_mb;
    logic [ADDR_W-1:0] len_d;

    always_comb begin
        unique case (size_i)
            2'b00: size_mb = 12'd1;
            2'b01: size_mb = 12'd2;
            2'b10: size_mb = 12'd8;
            default: size_mb = 12'(EXT_MB);
        endcase
        route_d.nsmm_low_ram  = open_i && !hen_i;
        route_d.nsmm_high_ram = open_i && hen_i;
        route_d.smm_low_ram   = gen_i && !hen_i;
        route_d.smm_high_ram  = gen_i && hen_i;
        route_d.tseg_en       = gen_i && ten_i;
        len_d = route_d.tseg_en ? (ADDR_W'(size_mb) << MB_SHIFT) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q     <= '0;
            tseg_base_q <= '0;
            tseg_len_q  <= '0;
        end else begin
            route_q     <= route_d;
            tseg_base_q <= top_low_mem - len_d;
            tseg_len_q  <= len_d;
        end
    end

    assert_high_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        route_q.nsmm_high_ram |-> $past(open_i && hen_i));
    assert_smm_needs_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q.smm_low_ram || route_q.smm_high_ram) |-> $past(gen_i));
    assert_tseg_needs_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        route_q.tseg_en |-> $past(gen_i && ten_i));
endmodule

// File: rtl/smm_tseg_check.sv
module smm_tseg_check #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tseg_en,
    input  logic [ADDR_W-1:0] tseg_base,
    input  logic [ADDR_W-1:0] top_low_mem,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              acc_blocked
);
    logic in_range;

    assign in_range    = (acc_addr >= tseg_base) && (acc_addr < top_low_mem);
    assign acc_blocked = tseg_en && !acc_smm && in_range;

    assert_smm_never_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_smm |-> !acc_blocked);
endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
    import smm_win_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EXT_MB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic [ADDR_W-1:0] top_low_mem,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic [7:0]        ctl_val,
    output logic [7:0]        ectl_val,
    output logic [15:0]       ext_val,
    output logic              nsmm_low_ram,
    output logic              nsmm_high_ram,
    output logic              smm_low_ram,
    output logic              smm_high_ram,
    output logic              tseg_en,
    output logic [ADDR_W-1:0] tseg_base,
    output logic [ADDR_W-1:0] tseg_len,
    output logic              acc_blocked
);
    route_t route;

    smm_cfg_regs #(.EXT_MB(EXT_MB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ctl_q     (ctl_val),
        .ectl_q    (ectl_val),
        .ext_q     (ext_val)
    );

    smm_route #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (ctl_val[OPEN_B]),
        .gen_i       (ctl_val[GEN_B]),
        .hen_i       (ectl_val[HEN_B]),
        .ten_i       (ectl_val[TEN_B]),
        .size_i      (ectl_val[2:1]),
        .top_low_mem (top_low_mem),
        .route_q     (route),
        .tseg_base_q (tseg_base),
        .tseg_len_q  (tseg_len)
    );

    assign nsmm_low_ram  = route.nsmm_low_ram;
    assign nsmm_high_ram = route.nsmm_high_ram;
    assign smm_low_ram   = route.smm_low_ram;
    assign smm_high_ram  = route.smm_high_ram;
    assign tseg_en       = route.tseg_en;

    smm_tseg_check #(.ADDR_W(ADDR_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .tseg_en     (route.tseg_en),
        .tseg_base   (tseg_base),
        .top_low_mem (top_low_mem),
        .acc_addr    (acc_addr),
        .acc_smm     (acc_smm),
        .acc_blocked (acc_blocked)
    );
endmodule

// File: tb/smm_window_ctrl_test.sv
module smm_window_ctrl_test;
    localparam int AW = 32;
    localparam logic [31:0] TOP = 32'h8000_0000;
    localparam int NVEC = 11;
    // {ctl write, ectl write, {nsl, nsh, sl, sh, ten}, tseg length}
    localparam logic [52:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 5'b00000, 32'h0000_0000},
        {8'h40, 8'h00, 5'b10000, 32'h0000_0000},
        {8'h40, 8'h80, 5'b01000, 32'h0000_0000},
        {8'h08, 8'h00, 5'b00100, 32'h0000_0000},
        {8'h08, 8'h80, 5'b00010, 32'h0000_0000},
        {8'h08, 8'h01, 5'b00101, 32'h0010_0000},
        {8'h08, 8'h03, 5'b00101, 32'h0020_0000},
        {8'h08, 8'h05, 5'b00101, 32'h0080_0000},
        {8'h08, 8'h07, 5'b00101, 32'h0100_0000},
        {8'h00, 8'h07, 5'b00000, 32'h0000_0000},
        {8'h48, 8'h81, 5'b01011, 32'h0010_0000}
    };

    logic clk = 0, rst_n = 0, cfg_we = 0, acc_smm = 0;
    logic [1:0] cfg_sel = 2'd3;
    logic [15:0] cfg_wdata = '0;
    logic [AW-1:0] top_low_mem = TOP, acc_addr = '0;
    logic [7:0] ctl_val, ectl_val;
    logic [15:0] ext_val;
    logic nsl, nsh, sl, sh, ten, acc_blocked;
    logic [AW-1:0] tseg_base, tseg_len;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    smm_window_ctrl #(.ADDR_W(AW), .EXT_MB(16)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .top_low_mem(top_low_mem), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .ctl_val(ctl_val), .ectl_val(ectl_val), .ext_val(ext_val),
        .nsmm_low_ram(nsl), .nsmm_high_ram(nsh), .smm_low_ram(sl), .smm_high_ram(sh),
        .tseg_en(ten), .tseg_base(tseg_base), .tseg_len(tseg_len), .acc_blocked(acc_blocked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 0; cfg_sel = 2'd3;
    endtask

    function automatic logic [4:0] routes();
        return {nsl, nsh, sl, sh, ten};
    endfunction

    task automatic probe(input logic [31:0] a, input logic s, input logic exp);
        acc_addr = a; acc_smm = s;
        #1 chk("R8 lookup", 32'(acc_blocked), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 ctl", 32'(ctl_val), 32'h02);
        chk("R1 ectl", 32'(ectl_val), 32'h38);
        chk("R1 ext", 32'(ext_val), 32'hFFFF);
        chk("R1 routes", 32'(routes()), 32'h0);
        chk("R1 tseg_len", tseg_len, 32'h0);

        // R2 write masks
        wr(2'd0, 16'h00EF); chk("R2 ctl mask", 32'(ctl_val), 32'h6A);
        wr(2'd1, 16'h00FF); chk("R2 ectl mask", 32'(ectl_val), 32'hBF);
        wr(2'd0, 16'h0000); chk("R2 ctl clear", 32'(ctl_val), 32'h02);
        wr(2'd1, 16'h0000); chk("R2 ectl clear", 32'(ectl_val), 32'h38);

        // R4 R5 R6 vector walk
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, {8'h00, VEC[i][52:45]});
            wr(2'd1, {8'h00, VEC[i][44:37]});
            @(negedge clk);
            chk("R4/R5/R6 routes", 32'(routes()), 32'(VEC[i][36:32]));
            chk("R6 tseg_len", tseg_len, VEC[i][31:0]);
            chk("R7 tseg_base", tseg_base, TOP - VEC[i][31:0]);
        end

        // R10 one-cycle lag
        wr(2'd1, 16'h0000);
        @(negedge clk);
        chk("R4 open low ram", 32'(nsl), 32'h1);
        wr(2'd0, 16'h0008);
        chk("R10 route still old", 32'(nsl), 32'h1);
        @(negedge clk);
        chk("R10 route updated", 32'(nsl), 32'h0);

        // R7 R8 TSEG region
        wr(2'd1, 16'h0001);
        @(negedge clk);
        chk("R7 base", tseg_base, 32'h7FF0_0000);
        probe(32'h7FF0_0000, 1'b0, 1'b1);
        probe(32'h7FEF_FFFF, 1'b0, 1'b0);
        probe(32'h7FFF_FFFF, 1'b0, 1'b1);
        probe(32'h8000_0000, 1'b0, 1'b0);
        probe(32'h7FF0_0000, 1'b1, 1'b0);
        acc_smm = 0;

        // R9 query handshake
        wr(2'd2, 16'h1234); chk("R9 plain value", 32'(ext_val), 32'h1234);
        wr(2'd2, 16'hFFFF); chk("R9 query swap", 32'(ext_val), 32'h0010);

        // R3 lock
        wr(2'd0, 16'h0058); chk("R3 open cleared", 32'(ctl_val), 32'h1A);
        @(negedge clk);
        chk("R3 low to pci", 32'(nsl), 32'h0);
        chk("R3 smm low", 32'(sl), 32'h1);
        wr(2'd0, 16'h0040); chk("R3 ctl frozen", 32'(ctl_val), 32'h1A);
        wr(2'd1, 16'h0080); chk("R3 ectl frozen", 32'(ectl_val), 32'h39);
        wr(2'd2, 16'h0042); chk("R3 ext writable", 32'(ext_val), 32'h0042);
        @(negedge clk);
        chk("R3 high stays off", 32'(nsh), 32'h0);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R3 reset ctl", 32'(ctl_val), 32'h02);
        chk("R1 reset ext", 32'(ext_val), 32'hFFFF);
        wr(2'd0, 16'h0040); chk("R3 mask restored", 32'(ctl_val), 32'h42);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule